// File: doc/BRIEF.md
# Serial Test-Pattern Transmitter

This block is a serial bit-stream source for link bring-up and bit-error testing. It sends one bit on each rising clock edge while it is running. Two sources are available: a pseudo-random sequence from a 7-stage linear feedback shift register (polynomial x^7 + x^6 + 1), or a 22-bit word that the user writes in and that repeats without end. Software drives it through a small byte-wide write port. Through that port it sets the enable and the source, writes the pattern bytes, and writes a seed. A seed write also restarts both generators.

The generator runs when an active-low enable pin is pulled low or when the software enable bit is set. While it is stopped, the data output, the generator state and the trigger divider all hold. A trigger output toggles once every eight running edges. Its period is therefore sixteen bit clocks, which gives an oscilloscope a steady reference to lock onto.

Top module: `prbs_pattern_tx`

## Requirements
- R1: After reset, data_o and trig_o are 0, the software enable and the mode bit are 0, the LFSR state is 1, the pattern index is at bit 21 and the pattern is all zero.
- R2: The block runs on an edge when tx_en_ni is 0 or the enable bit (bit 0 of the register at address 0x00) is 1. A write to that register takes effect from the following edge.
- R3: On an edge where the block is not running, data_o, trig_o, the LFSR state, the pattern index and the trigger divider all keep their values.
- R4: With the mode bit (bit 1 of address 0x00) at 0, each running edge loads data_o with LFSR bit 6. The state then shifts left, and the new bit 0 is bit6 XOR bit5, so the output repeats every 127 bits.
- R5: A write to address 0x01 loads wr_data_i[6:0] into the LFSR. A seed of 0 is replaced by 1, so the state is never all zero. Writing 0x01 gives the standard start point.
- R6: A seed write also returns the pattern index to bit 21. On that edge neither generator advances and data_o holds.
- R7: With the mode bit at 1, each running edge loads data_o with the pattern bit at the current index. The index then steps from 21 down to 0 and wraps back to 21.
- R8: Pattern bits [7:0] are written at address 0x02 and bits [15:8] at 0x03. Bits [21:16] come from wr_data_i[5:0] at 0x04, and the upper two data bits of that write are dropped.
- R9: trig_o toggles on every eighth running edge counted from reset, so its period is 16 running clocks. The divider keeps counting on seed-write edges.
- R10: Writes to any address outside 0x00 to 0x04 change no state and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_ni | input | 1 | External run enable, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register write address |
| wr_data_i | input | 8 | Register write data |
| data_o | output | 1 | Serial test data |
| trig_o | output | 1 | Scope trigger, bit clock divided by 16 |

## Verification
The bench builds the block with its default parameters. These are a 7-stage register tapped at stage 6, a 22-bit pattern spread over three byte addresses, and a divide-by-16 trigger. The run covers more than one full 127-bit sequence and several wraps of the pattern index. It reaches the partial top pattern byte, a zero seed, and a seed write in the middle of a pattern. It also switches between pin enable and software enable with pauses in between, and checks that the stream and the trigger phase continue unbroken after each pause.

// File: rtl/prbs_tx_pkg.sv
package prbs_tx_pkg;
  typedef enum logic {MODE_PRBS = 1'b0, MODE_PAT = 1'b1} tx_mode_e;
  localparam int unsigned OFS_CTRL = 0;
  localparam int unsigned OFS_SEED = 1;
  localparam int unsigned OFS_PAT  = 2;
  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_MODE_BIT = 1;
endpackage

// File: rtl/prbs_tx_regs.sv
module prbs_tx_regs
  import prbs_tx_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PAT_W  = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              en_o,
  output tx_mode_e          mode_o,
  output logic [PAT_W-1:0]  pat_o,
  output logic              seed_wr_o
);
  logic ctrl_wr;
  assign ctrl_wr   = wr_en_i && (wr_addr_i == ADDR_W'(OFS_CTRL));
  assign seed_wr_o = wr_en_i && (wr_addr_i == ADDR_W'(OFS_SEED));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= 1'b0;
      mode_o <= MODE_PRBS;
    end else if (ctrl_wr) begin
      en_o   <= wr_data_i[CTRL_EN_BIT];
      mode_o <= tx_mode_e'(wr_data_i[CTRL_MODE_BIT]);
    end
  end

  // pattern spread over consecutive byte addresses, LSB byte first
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pat_o <= '0;
    end else begin
      for (int b = 0; b < PAT_W; b++) begin
        if (wr_en_i && (wr_addr_i == ADDR_W'(OFS_PAT + b / DATA_W)))
          pat_o[b] <= wr_data_i[b % DATA_W];
      end
    end
  end
endmodule

// File: rtl/prbs_tx_lfsr.sv
module prbs_tx_lfsr #(
  parameter int unsigned W   = 7,
  parameter int unsigned TAP = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  input  logic         step_i,
  output logic [W-1:0] state_o,
  output logic         bit_o
);
  assign bit_o = state_o[W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      state_o <= W'(1);
    else if (load_i)
      state_o <= (seed_i == '0) ? W'(1) : seed_i;
    else if (step_i)
      state_o <= {state_o[W-2:0], state_o[W-1] ^ state_o[TAP-1]};
  end
endmodule

// File: rtl/prbs_tx_pattern.sv
module prbs_tx_pattern #(
  parameter int unsigned PAT_W = 22,
  localparam int unsigned IW   = $clog2(PAT_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             step_i,
  input  logic [PAT_W-1:0] pat_i,
  output logic [IW-1:0]    idx_o,
  output logic             bit_o
);
  localparam logic [IW-1:0] TOP = IW'(PAT_W - 1);

  assign bit_o = pat_i[idx_o];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      idx_o <= TOP;
    else if (restart_i)
      idx_o <= TOP;
    else if (step_i)
      idx_o <= (idx_o == '0) ? TOP : idx_o - 1'b1;
  end
endmodule

// File: rtl/prbs_tx_trig_div.sv
module prbs_tx_trig_div #(
  parameter int unsigned DIV = 16,
  localparam int unsigned CW = $clog2(DIV) - 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  output logic trig_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      trig_o <= 1'b0;
    end else if (adv_i) begin
      cnt_q <= cnt_q + 1'b1;
      if (&cnt_q) trig_o <= ~trig_o;
    end
  end
endmodule

// File: rtl/prbs_pattern_tx.sv
module prbs_pattern_tx
  import prbs_tx_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned LFSR_W   = 7,
  parameter int unsigned LFSR_TAP = 6,
  parameter int unsigned PAT_W    = 22,
  parameter int unsigned TRIG_DIV = 16,
  localparam int unsigned IW      = $clog2(PAT_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              data_o,
  output logic              trig_o
);
  logic              sw_en;
  tx_mode_e          mode;
  logic [PAT_W-1:0]  pat_q;
  logic              seed_wr;
  logic              run;
  logic              step;
  logic [LFSR_W-1:0] lfsr_q;
  logic              lfsr_bit;
  logic [IW-1:0]     pat_idx;
  logic              pat_bit;

  assign run  = ~tx_en_ni | sw_en;
  assign step = run & ~seed_wr;

  prbs_tx_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAT_W(PAT_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .en_o(sw_en), .mode_o(mode), .pat_o(pat_q), .seed_wr_o(seed_wr)
  );

  prbs_tx_lfsr #(.W(LFSR_W), .TAP(LFSR_TAP)) u_lfsr (
    .clk_i, .rst_ni, .load_i(seed_wr), .seed_i(wr_data_i[LFSR_W-1:0]),
    .step_i(step), .state_o(lfsr_q), .bit_o(lfsr_bit)
  );

  prbs_tx_pattern #(.PAT_W(PAT_W)) u_pat (
    .clk_i, .rst_ni, .restart_i(seed_wr), .step_i(step),
    .pat_i(pat_q), .idx_o(pat_idx), .bit_o(pat_bit)
  );

  prbs_tx_trig_div #(.DIV(TRIG_DIV)) u_trig (
    .clk_i, .rst_ni, .adv_i(run), .trig_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   data_o <= 1'b0;
    else if (step) data_o <= (mode == MODE_PAT) ? pat_bit : lfsr_bit;
  end
endmodule

// File: rtl/prbs_pattern_tx_chk.sv
module prbs_pattern_tx_chk
  import prbs_tx_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LFSR_W = 7,
  parameter int unsigned PAT_W  = 22,
  localparam int unsigned IW    = $clog2(PAT_W)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tx_en_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              sw_en,
  input tx_mode_e          mode,
  input logic              seed_wr,
  input logic [LFSR_W-1:0] lfsr_q,
  input logic [IW-1:0]     pat_idx,
  input logic              pat_bit,
  input logic              data_o,
  input logic              trig_o
);
  logic seed_req, act;
  assign seed_req = wr_en_i && (wr_addr_i == ADDR_W'(OFS_SEED));
  assign act      = !tx_en_ni || sw_en;

  AST_LFSR_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != '0); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act |=> $stable(data_o) && $stable(trig_o)); // R3
  AST_TRIG_ONLY_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(trig_o) |-> $past(act)); // R9
  AST_SEED_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_req |=> lfsr_q == (($past(wr_data_i[LFSR_W-1:0]) == '0) ? LFSR_W'(1)
                                                                 : $past(wr_data_i[LFSR_W-1:0]))); // R5
  AST_RESTART_MSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_req |=> pat_idx == IW'(PAT_W - 1) && $stable(data_o)); // R6
  AST_PRBS_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act && !seed_req && mode == MODE_PRBS |=> data_o == $past(lfsr_q[LFSR_W-1])); // R4
  AST_PAT_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act && !seed_req && mode == MODE_PAT |=> data_o == $past(pat_bit)); // R7
  AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pat_idx < IW'(PAT_W)); // R7
  AST_SEED_DECODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_wr == seed_req); // R10
endmodule

bind prbs_pattern_tx prbs_pattern_tx_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LFSR_W(LFSR_W), .PAT_W(PAT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tx_en_ni(tx_en_ni), .wr_en_i(wr_en_i),
  .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .sw_en(sw_en), .mode(mode),
  .seed_wr(seed_wr), .lfsr_q(lfsr_q), .pat_idx(pat_idx), .pat_bit(pat_bit),
  .data_o(data_o), .trig_o(trig_o)
);

// File: tb/prbs_pattern_tx_bench.sv
module prbs_pattern_tx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en_n = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       data_o, trig_o;

  always #2 clk = ~clk;

  prbs_pattern_tx u_prbs_pattern_tx (
    .clk_i(clk), .rst_ni(rst_n), .tx_en_ni(tx_en_n), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .data_o(data_o), .trig_o(trig_o)
  );

  typedef struct {logic d; logic t; string req;} exp_t;
  exp_t q[$];
  int tests = 0, fails = 0;
  string cur_req = "R1";
  bit done = 0;

  // reference model state
  logic [6:0]  m_lfsr = 7'd1;
  int          m_idx = 21;
  logic [21:0] m_pat = '0;
  logic        m_en = 0, m_mode = 0, m_data = 0, m_trig = 0;
  int          m_cnt = 0;

  task automatic check(input string req, input logic ad, input logic at,
                       input logic ed, input logic et);
    tests++;
    if (ad !== ed || at !== et) begin
      fails++;
      $display("FAIL %s data=%b trig=%b expected data=%b trig=%b", req, ad, at, ed, et);
    end
  endtask

  // driver: apply one cycle, advance model, push expectation
  task automatic cyc(input logic en_n, input logic we, input logic [7:0] a,
                     input logic [7:0] d);
    logic run;
    tx_en_n = en_n; wr_en = we; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    run = !en_n || m_en;
    if (we && a == 8'h01) begin
      m_lfsr = (d[6:0] == 0) ? 7'd1 : d[6:0];
      m_idx = 21;
    end else if (run) begin
      m_data = m_mode ? m_pat[m_idx] : m_lfsr[6];
      m_lfsr = {m_lfsr[5:0], m_lfsr[6] ^ m_lfsr[5]};
      m_idx = (m_idx == 0) ? 21 : m_idx - 1;
    end
    if (run) begin
      m_cnt++;
      if (m_cnt == 8) begin m_cnt = 0; m_trig = !m_trig; end
    end
    if (we && a == 8'h00) begin m_en = d[0]; m_mode = d[1]; end
    for (int b = 0; b < 22; b++)
      if (we && a == 8'(2 + b / 8)) m_pat[b] = d[b % 8];
    q.push_back('{m_data, m_trig, cur_req});
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input logic en_n, input int n);
    for (int i = 0; i < n; i++) cyc(en_n, 1'b0, 8'h00, 8'h00);
  endtask

  // monitor
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(e.req, data_o, trig_o, e.d, e.t);
    end
  end

  initial begin
    #800000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #5;
    check("R1", data_o, trig_o, 1'b0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1", data_o, trig_o, 1'b0, 1'b0);

    cur_req = "R3";  idle(1'b1, 5);
    cur_req = "R5";  cyc(1'b1, 1'b1, 8'h01, 8'h01);
    cur_req = "R2";  cyc(1'b1, 1'b1, 8'h00, 8'h01);
    cur_req = "R4";  idle(1'b1, 140);
    cur_req = "R9";  idle(1'b1, 20);
    cur_req = "R3";  cyc(1'b1, 1'b1, 8'h00, 8'h00); idle(1'b1, 11);
    cur_req = "R2";  idle(1'b0, 20);
    cur_req = "R5";  cyc(1'b0, 1'b1, 8'h01, 8'h00); idle(1'b0, 10);
    cyc(1'b0, 1'b1, 8'h01, 8'h55); idle(1'b0, 10);
    cur_req = "R8";  cyc(1'b0, 1'b1, 8'h02, 8'hA5);
    cyc(1'b0, 1'b1, 8'h03, 8'hC3);
    cyc(1'b0, 1'b1, 8'h04, 8'hFF);
    cur_req = "R7";  cyc(1'b1, 1'b1, 8'h00, 8'h03);
    cur_req = "R6";  cyc(1'b1, 1'b1, 8'h01, 8'h01);
    cur_req = "R7";  idle(1'b1, 50);
    cur_req = "R10"; cyc(1'b1, 1'b1, 8'h07, 8'hFF);
    cyc(1'b1, 1'b1, 8'h05, 8'hFF); idle(1'b1, 30);
    cur_req = "R6";  cyc(1'b0, 1'b1, 8'h01, 8'h7F); idle(1'b0, 25);
    cur_req = "R3";  cyc(1'b1, 1'b1, 8'h00, 8'h02); idle(1'b1, 8);
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule